// File: doc/BRIEF.md
# Variable-Latency Speculative-Carry Adder

This block adds two unsigned operands modulo 2^W. The operand width is split into equal segments, and each segment adds on its own. A segment does not wait for the carry from the segments below it. Instead it predicts its carry-in from a short window of the bits just under its boundary, assuming that no carry enters that window. Because the carry chain is broken this way, the common path is only as deep as one segment plus one small window.

The prediction can only be wrong when every bit of a window propagates, that is when `a ^ b` is all ones across the window. A wide AND over each window finds this case. The result is then held back for one extra cycle. In that cycle the true segment carries are rippled from the stored operands, and each segment that was predicted wrongly is incremented. The block has a valid/ready input side. `in_ready` drops for the correction cycle, so throughput falls only on operations that were flagged. Every result leaves as a one-cycle `out_valid` pulse, with a flag that says whether it took the slow path. Results come out in the order the operations were accepted.

Top module: `varlat_approx_adder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0, `out_fixed` is 0 and `in_ready` is 1.
- R2: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. An accepted operation that is not flagged (see R3) gives `out_valid`=1 and `out_fixed`=0 in the next cycle, and `out_sum` equals `(in_a + in_b) mod 2^W`.
- R3: An operation is flagged when, for some segment index j from 1 to W/SEG_W-1, bits `j*SEG_W-LOOK_W` up to `j*SEG_W-1` of `in_a ^ in_b` are all 1. The result of a flagged operation appears two cycles after acceptance, with `out_fixed`=1.
- R4: The sum of a flagged operation is exact modulo 2^W. This includes operations whose carry runs through several segments and operations that wrap past the top bit.
- R5: In the single cycle that follows the acceptance of a flagged operation, `in_ready` is 0. In that cycle an asserted `in_valid` is ignored and produces no result. `in_ready` is 1 in every other cycle after reset.
- R6: Operations that are not flagged can be accepted in every cycle. They then give one result per cycle, in acceptance order.
- R7: `out_valid` pulses exactly once for each accepted operation and at no other time.
- R8: A run of propagating bits that lies wholly outside every window does not flag the operation. Examples are bits 0 and 1, bits 8 and 9, and the top segment at the default parameters.
- R9: Flagging is conservative. An all-propagate window flags the operation even when no carry actually enters the window, and the sum is still exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Block can take operands this cycle |
| in_a | input | W | First addend |
| in_b | input | W | Second addend |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | W | Sum modulo 2^W |
| out_fixed | output | 1 | Result took the correction cycle |

## Verification
Two things can happen on the same edge. A corrected result can leave while `in_ready` returns, and a new operation, possibly flagged again, is accepted on that very edge. Likewise, a fast result can leave on the same edge that accepts a flagged operation that stalls the next cycle. The bench provokes both by keeping `in_valid` high across long mixed streams of random and boundary-straddling propagate runs, and by driving junk operands during each stall. Every accepted operation is queued with the cycle in which its result is due. Each result must match the front of the queue in sum, flag and arrival cycle, and `in_ready` is compared in every cycle against the stall the bench predicts.

// File: rtl/vla_pkg.sv
package vla_pkg;

    // Controller phase: normal single-cycle operation or the correction cycle
    typedef enum logic {
        PH_RUN = 1'b0,
        PH_FIX = 1'b1
    } phase_e;

    // One step of a generate/propagate carry ripple
    function automatic logic chain_carry(input logic gen, input logic prop, input logic cin);
        return gen | (prop & cin);
    endfunction

endpackage

// File: rtl/vla_spec_sum.sv
// Segmented adder with windowed carry prediction and per-boundary risk flags.
module vla_spec_sum #(
    parameter  int W      = 16,
    parameter  int SEG_W  = 4,
    parameter  int LOOK_W = 2,
    localparam int NSEG   = W / SEG_W
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    sum,
    output logic [NSEG-1:0] cpred,
    output logic [NSEG-1:0] risk
);

    for (genvar j = 0; j < NSEG; j++) begin : g_seg
        logic [SEG_W-1:0] sa;
        logic [SEG_W-1:0] sb;
        assign sa = a[j*SEG_W +: SEG_W];
        assign sb = b[j*SEG_W +: SEG_W];

        if (j == 0) begin : g_low
            assign cpred[0] = 1'b0;
            assign risk[0]  = 1'b0;
        end else begin : g_pred
            logic [LOOK_W-1:0] wa;
            logic [LOOK_W-1:0] wb;
            logic [LOOK_W:0]   wsum;
            assign wa       = a[j*SEG_W-LOOK_W +: LOOK_W];
            assign wb       = b[j*SEG_W-LOOK_W +: LOOK_W];
            // Window added with zero carry-in: its carry-out is the prediction
            assign wsum     = {1'b0, wa} + {1'b0, wb};
            assign cpred[j] = wsum[LOOK_W];
            // Prediction can only be wrong when the whole window propagates
            assign risk[j]  = &(wa ^ wb);
        end

        assign sum[j*SEG_W +: SEG_W] = sa + sb + {{(SEG_W-1){1'b0}}, cpred[j]};
    end

endmodule

// File: rtl/vla_fixup.sv
// Correction path: exact segment carries from held operands, incrementing
// every segment whose predicted carry was too low.
module vla_fixup import vla_pkg::*; #(
    parameter  int W     = 16,
    parameter  int SEG_W = 4,
    localparam int NSEG  = W / SEG_W,
    localparam int LOW_W = W - SEG_W
) (
    input  logic [LOW_W-1:0] a_low,
    input  logic [LOW_W-1:0] b_low,
    input  logic [W-1:0]     spec_sum,
    input  logic [NSEG-1:0]  cpred,
    output logic [W-1:0]     fixed_sum
);

    logic [NSEG-2:0] seg_g;
    logic [NSEG-2:0] seg_p;
    logic [NSEG-1:0] ctrue;
    logic [NSEG-1:0] bump;

    // Segment-level generate and propagate (top segment's carry-out is dropped)
    for (genvar j = 0; j < NSEG-1; j++) begin : g_gp
        logic [SEG_W-1:0] sa;
        logic [SEG_W-1:0] sb;
        logic [SEG_W:0]   t;
        assign sa       = a_low[j*SEG_W +: SEG_W];
        assign sb       = b_low[j*SEG_W +: SEG_W];
        assign t        = {1'b0, sa} + {1'b0, sb};
        assign seg_g[j] = t[SEG_W];
        assign seg_p[j] = &(sa ^ sb);
    end

    always_comb begin
        ctrue = '0;
        for (int j = 0; j < NSEG-1; j++) begin
            ctrue[j+1] = chain_carry(seg_g[j], seg_p[j], ctrue[j]);
        end
    end

    // A predicted carry of 1 is always right; only 0-to-1 fixes are needed
    assign bump = ctrue & ~cpred;

    for (genvar j = 0; j < NSEG; j++) begin : g_inc
        assign fixed_sum[j*SEG_W +: SEG_W] =
            spec_sum[j*SEG_W +: SEG_W] + {{(SEG_W-1){1'b0}}, bump[j]};
    end

endmodule

// File: rtl/vla_ctrl.sv
// Handshake and latency control: one-cycle path or hold-and-correct path.
module vla_ctrl import vla_pkg::*; #(
    parameter  int W     = 16,
    parameter  int SEG_W = 4,
    localparam int NSEG  = W / SEG_W,
    localparam int LOW_W = W - SEG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LOW_W-1:0] in_a_low,
    input  logic [LOW_W-1:0] in_b_low,
    input  logic [W-1:0]     spec_sum,
    input  logic [NSEG-1:0]  cpred,
    input  logic [NSEG-1:0]  risk,
    input  logic [W-1:0]     fixed_sum,
    output logic             in_ready,
    output logic [LOW_W-1:0] hold_a,
    output logic [LOW_W-1:0] hold_b,
    output logic [W-1:0]     hold_sum,
    output logic [NSEG-1:0]  hold_c,
    output logic             out_valid,
    output logic [W-1:0]     out_sum,
    output logic             out_fixed
);

    phase_e phase;
    logic   risky;

    assign risky    = |risk;
    assign in_ready = (phase == PH_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_RUN;
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_fixed <= 1'b0;
            hold_a    <= '0;
            hold_b    <= '0;
            hold_sum  <= '0;
            hold_c    <= '0;
        end else begin
            out_valid <= 1'b0;
            if (phase == PH_FIX) begin
                out_valid <= 1'b1;
                out_sum   <= fixed_sum;
                out_fixed <= 1'b1;
                phase     <= PH_RUN;
            end else if (in_valid) begin
                if (risky) begin
                    hold_a   <= in_a_low;
                    hold_b   <= in_b_low;
                    hold_sum <= spec_sum;
                    hold_c   <= cpred;
                    phase    <= PH_FIX;
                end else begin
                    out_valid <= 1'b1;
                    out_sum   <= spec_sum;
                    out_fixed <= 1'b0;
                end
            end
        end
    end

    // R5: the correction phase never lasts more than one cycle
    assert_fix_single_cycle_R5: assert property (
        @(posedge clk) disable iff (rst)
        (phase == PH_FIX) |=> (phase == PH_RUN)
    );

endmodule

// File: rtl/varlat_approx_adder.sv
module varlat_approx_adder import vla_pkg::*; #(
    parameter  int W      = 16,
    parameter  int SEG_W  = 4,
    parameter  int LOOK_W = 2,
    localparam int NSEG   = W / SEG_W,
    localparam int LOW_W  = W - SEG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_sum,
    output logic         out_fixed
);

    if ((W % SEG_W) != 0 || NSEG < 2 || LOOK_W < 1 || LOOK_W > SEG_W) begin : g_bad_cfg
        $error("varlat_approx_adder: unsupported W/SEG_W/LOOK_W combination");
    end

    logic [W-1:0]     spec_sum;
    logic [NSEG-1:0]  cpred;
    logic [NSEG-1:0]  risk;
    logic [LOW_W-1:0] hold_a;
    logic [LOW_W-1:0] hold_b;
    logic [W-1:0]     hold_sum;
    logic [NSEG-1:0]  hold_c;
    logic [W-1:0]     fixed_sum;
    logic [W-1:0]     ref_sum;

    vla_spec_sum #(.W(W), .SEG_W(SEG_W), .LOOK_W(LOOK_W)) u_spec (
        .a     (in_a),
        .b     (in_b),
        .sum   (spec_sum),
        .cpred (cpred),
        .risk  (risk)
    );

    vla_fixup #(.W(W), .SEG_W(SEG_W)) u_fix (
        .a_low     (hold_a),
        .b_low     (hold_b),
        .spec_sum  (hold_sum),
        .cpred     (hold_c),
        .fixed_sum (fixed_sum)
    );

    vla_ctrl #(.W(W), .SEG_W(SEG_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a_low  (in_a[LOW_W-1:0]),
        .in_b_low  (in_b[LOW_W-1:0]),
        .spec_sum  (spec_sum),
        .cpred     (cpred),
        .risk      (risk),
        .fixed_sum (fixed_sum),
        .in_ready  (in_ready),
        .hold_a    (hold_a),
        .hold_b    (hold_b),
        .hold_sum  (hold_sum),
        .hold_c    (hold_c),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_fixed (out_fixed)
    );

    // Full-width reference sum used only by the checks below
    assign ref_sum = in_a + in_b;

    // R2: unflagged operation gives the exact sum one cycle later
    assert_fast_exact_R2: assert property (
        @(posedge clk) disable iff (rst)
        (in_valid && in_ready && !(|risk))
            |=> (out_valid && !out_fixed && out_sum == $past(ref_sum))
    );

    // R3: flagged operation produces no result yet and stalls the input
    assert_slow_stalls_R3: assert property (
        @(posedge clk) disable iff (rst)
        (in_valid && in_ready && (|risk)) |=> (!out_valid && !in_ready)
    );

    // R4: corrected result equals the exact sum of the operands taken two cycles earlier
    assert_fixed_exact_R4: assert property (
        @(posedge clk) disable iff (rst)
        (out_valid && out_fixed) |-> (out_sum == $past(ref_sum, 2) && $past(!in_ready))
    );

    // R7: a fast result always follows an accepted operation
    assert_no_orphan_R7: assert property (
        @(posedge clk) disable iff (rst)
        (out_valid && !out_fixed) |-> $past(in_valid && in_ready)
    );

endmodule

// File: tb/test_varlat_approx_adder.sv
`timescale 1ns/1ps
module test_varlat_approx_adder;
    localparam int W      = 16;
    localparam int SEG_W  = 4;
    localparam int LOOK_W = 2;
    localparam int NSEG   = W / SEG_W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         in_ready;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_fixed;

    typedef struct {
        logic [W-1:0] sum;
        logic         fix;
        int           due;
        string        req;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   stall_cyc = -5;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    varlat_approx_adder #(.W(W), .SEG_W(SEG_W), .LOOK_W(LOOK_W)) i_varlat_approx_adder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_fixed (out_fixed)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // R3 flag rule: some window just below a segment boundary fully propagates
    function automatic logic will_flag(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] x;
        x = a ^ b;
        for (int j = 1; j < NSEG; j++) begin
            logic all1;
            all1 = 1'b1;
            for (int k = 0; k < LOOK_W; k++) all1 &= x[j*SEG_W-LOOK_W+k];
            if (all1) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Driver: offers junk during stalls (R5), then one real operation
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic f;
        @(negedge clk);
        while (!in_ready) begin
            in_valid = 1'b1;
            in_a     = W'($urandom);
            in_b     = W'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_a     = a;
        in_b     = b;
        f        = will_flag(a, b);
        sb.push_back('{sum: a + b, fix: f, due: cyc + (f ? 2 : 1), req: req});
        if (f) stall_cyc = cyc + 1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            check(in_ready == (cyc != stall_cyc), "R5", "in_ready",
                  W'(in_ready), W'(cyc != stall_cyc));
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7", "unexpected result", out_sum, '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_sum == e.sum, e.req, "sum", out_sum, e.sum);
                    check(out_fixed == e.fix, "R3", "out_fixed", W'(out_fixed), W'(e.fix));
                    check(cyc == e.due, e.fix ? "R3" : "R2", "latency (cycle)",
                          W'(cyc), W'(e.due));
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", W'(out_valid), '0);
        check(out_fixed == 1'b0, "R1", "out_fixed in reset", W'(out_fixed), '0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", W'(in_ready), W'(1));
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", W'(out_valid), '0);

        // Directed cases
        send(16'h0000, 16'h0000, "R2");
        send(16'h000C, 16'h000C, "R2");   // window generates: predicted carry used
        send(16'hFFFF, 16'h0001, "R4");   // propagate through every boundary, wrap
        send(16'h0FFF, 16'h0001, "R4");   // carry ripples across three segments
        send(16'h00F0, 16'h0010, "R4");   // single boundary with real carry
        send(16'h000C, 16'h0000, "R9");   // flagged with no incoming carry
        send(16'h0C00, 16'h0000, "R9");
        send(16'h0003, 16'h0000, "R8");   // run in bits 0..1 only
        send(16'h0303, 16'h0000, "R8");   // runs outside every window
        send(16'hF000, 16'h0000, "R8");   // top segment only
        send(16'h7FFF, 16'h7FFF, "R4");
        idle(4);

        // R6: back-to-back unflagged stream
        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            do begin
                a = W'($urandom);
                b = W'($urandom);
            end while (will_flag(a, b));
            send(a, b, "R6");
        end
        idle(3);

        // Random mix with long propagate runs and occasional gaps
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'($urandom);
            if (n % 3 == 0) b = ~a ^ W'(1 << ($urandom % W));
            else            b = W'($urandom);
            send(a, b, will_flag(a, b) ? "R4" : "R2");
            if (n % 17 == 0) idle(1 + n % 3);
        end
        idle(6);

        check(sb.size() == 0, "R7", "results outstanding", W'(sb.size()), '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule